// File: doc/BRIEF.md
# Device Power State Sequencer

This block tracks the power state of a peripheral on a shared bus. Software can put the peripheral into a low-power state, and a bus reset brings it back to full operation. The block watches two kinds of configuration write: writes to the power-state field, and writes to the command register's memory and IO access enable bits. It also watches the active-low bus reset. The bus reset is brought in through a two-flop synchronizer, and the block acts on the synchronized level and on its rising edge.

There are four states: active (D0A), low power (D3), reset-held (DR) and uninitialized (D0U). From the block's outputs, the surrounding logic learns:
- whether to drive the bus pins;
- whether to drive the wake-event pin, which is driven at all times;
- when to reload configuration from non-volatile memory;
- when to clear the wakeup enable;
- which 2-bit power status to report.

When the bus reset is released, the block holds its outputs off for a fixed settling window. It then waits in D0U until software enables access.

Top module: `pwr_seq`

## Requirements
- R1: In D0A, a power-field write (`cfg_wr_i`) with value 2'b11 moves the block to D3 on the next clock.
- R2: D3 is left only by a bus reset. With no bus reset the block stays in D3 indefinitely, and power-field writes of any value there are ignored.
- R3: A low level on `bus_rst_ni` is seen through a two-flop synchronizer, and the block enters DR on the third clock edge after the input falls, from any state. In DR `bus_oe_o` is 0. `wake_pin_oe_o` is 1 in every state, including under `rst_ni`.
- R4: On the synchronized rising edge of `bus_rst_ni`, `nvm_reload_o` and `wake_clr_o` are each high for exactly one cycle. Both are visible after the second clock edge that samples the high input.
- R5: The block enters D0U exactly SETTLE_CYC clock cycles after the cycle in which the R4 pulses are high. `bus_oe_o` is 1 only in D0A and D0U.
- R6: In D0U, `pwr_status_o` equals {1'b0, `wake_opt_i`}.
- R7: In D0U, a command write (`cmd_wr_i`) with `cmd_mem_en_i` or `cmd_io_en_i` set moves the block to D0A on the next clock. In D0A `pwr_status_o` is 2'b11.
- R8: D0U has no timeout. A command write with both enable bits clear leaves the block in D0U.
- R9: In D0A, power-field writes of 2'b00, 2'b01 or 2'b10 are ignored. Command writes in D0A, D3 or DR (including during the settling window) are ignored.
- R10: The settling count is held at zero while the synchronized reset is low, and restarts from zero at every release. A reset that is re-asserted during settling delays D0U until SETTLE_CYC cycles after the last release pulse.
- R11: `state_o` encodes D0A=2'b00, D0U=2'b01, DR=2'b10, D3=2'b11. `pwr_status_o` is 2'b00 in D3 and DR. While `rst_ni` is low, the block is in DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_rst_ni | input | 1 | Active-low bus reset, asynchronous to the logic |
| cfg_wr_i | input | 1 | One-cycle strobe for a write to the power-state field |
| cfg_pstate_i | input | 2 | Value written to the power-state field |
| cmd_wr_i | input | 1 | One-cycle strobe for a write to the command register |
| cmd_mem_en_i | input | 1 | Memory access enable bit of the command write |
| cmd_io_en_i | input | 1 | IO access enable bit of the command write |
| wake_opt_i | input | 1 | Wake option enabled |
| bus_oe_o | output | 1 | Output enable for all bus pins except the wake pin |
| wake_pin_oe_o | output | 1 | Output enable for the wake-event pin |
| nvm_reload_o | output | 1 | One-cycle request to reload configuration from non-volatile memory |
| wake_clr_o | output | 1 | One-cycle pulse that clears the wakeup enable |
| pwr_status_o | output | 2 | Power status output |
| state_o | output | 2 | Encoded current state |

## Verification
The bench counts the cycles from the release pulse to the first D0U cycle. A counter off by one, or one that starts at the raw input edge instead of the synchronized edge, gives a different count. The bench re-asserts the bus reset in the middle of settling. A counter that resumes instead of restarting then enters D0U about 200 cycles too early. The bench holds D3 and D0U for thousands of cycles and sends writes that should be ignored: non-11 power values, enable-free command writes, and command writes during settling. Any stray transition, or a hidden timeout, would change `state_o`. Reset is applied from D0A, D0U and D3 to show that DR is reachable from every state. The R4 pulses are checked to be exactly one cycle wide.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_D0A = 2'b00,
    PS_D0U = 2'b01,
    PS_DR  = 2'b10,
    PS_D3  = 2'b11
  } pwr_state_e;

  localparam logic [1:0] PWR_FIELD_D3 = 2'b11;
  localparam logic [1:0] STATUS_ACTIVE = 2'b11;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_ni,
  output logic bus_up_o,
  output logic release_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], bus_rst_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign bus_up_o  = sync_q[STAGES-1];
  assign release_o = sync_q[STAGES-1] & ~prev_q;

  p_release_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !release_o);
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int unsigned SETTLE_CYC = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_cnt_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_up_i,
  input  logic       settle_done_i,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_pstate_i,
  input  logic       cmd_wr_i,
  input  logic       cmd_mem_en_i,
  input  logic       cmd_io_en_i,
  output pwr_state_e state_o
);
  pwr_state_e state_q, state_d;
  logic       to_d3, to_active;

  assign to_d3     = cfg_wr_i && (cfg_pstate_i == PWR_FIELD_D3);
  assign to_active = cmd_wr_i && (cmd_mem_en_i || cmd_io_en_i);

  always_comb begin
    state_d = state_q;
    if (!bus_up_i) begin
      state_d = PS_DR;
    end else begin
      unique case (state_q)
        PS_D0A:  if (to_d3)         state_d = PS_D3;
        PS_D0U:  if (to_active)     state_d = PS_D0A;
        PS_DR:   if (settle_done_i) state_d = PS_D0U;
        default: state_d = state_q;  // D3 waits for reset
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_DR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_enter_d3_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_D0A && bus_up_i && cfg_wr_i && cfg_pstate_i == 2'b11) |=> state_q == PS_D3);
  p_hold_d3_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_D3 && bus_up_i) |=> state_q == PS_D3);
  p_reset_to_dr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_up_i |=> state_q == PS_DR);
  p_enable_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_D0U && bus_up_i && cmd_wr_i && (cmd_mem_en_i || cmd_io_en_i)) |=> state_q == PS_D0A);
  p_d0u_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_D0U && bus_up_i && !cmd_wr_i) |=> state_q == PS_D0U);
endmodule

// File: rtl/pwr_status_enc.sv
module pwr_status_enc
  import pwr_seq_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       wake_opt_i,
  output logic       bus_oe_o,
  output logic       wake_pin_oe_o,
  output logic [1:0] pwr_status_o,
  output logic [1:0] state_code_o
);
  always_comb begin
    bus_oe_o     = 1'b0;
    pwr_status_o = 2'b00;
    unique case (state_i)
      PS_D0A: begin
        bus_oe_o     = 1'b1;
        pwr_status_o = STATUS_ACTIVE;
      end
      PS_D0U: begin
        bus_oe_o     = 1'b1;
        pwr_status_o = {1'b0, wake_opt_i};
      end
      default: ;
    endcase
  end

  assign wake_pin_oe_o = 1'b1;  // wake pin stays driven through reset
  assign state_code_o  = state_i;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rst_ni,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_pstate_i,
  input  logic       cmd_wr_i,
  input  logic       cmd_mem_en_i,
  input  logic       cmd_io_en_i,
  input  logic       wake_opt_i,
  output logic       bus_oe_o,
  output logic       wake_pin_oe_o,
  output logic       nvm_reload_o,
  output logic       wake_clr_o,
  output logic [1:0] pwr_status_o,
  output logic [1:0] state_o
);
  logic       bus_up, release_pulse, settle_done;
  pwr_state_e state;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_ni (bus_rst_ni),
    .bus_up_o   (bus_up),
    .release_o  (release_pulse)
  );

  pwr_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!bus_up),
    .run_i  (bus_up && state == PS_DR),
    .done_o (settle_done)
  );

  pwr_state_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_up_i      (bus_up),
    .settle_done_i (settle_done),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_pstate_i  (cfg_pstate_i),
    .cmd_wr_i      (cmd_wr_i),
    .cmd_mem_en_i  (cmd_mem_en_i),
    .cmd_io_en_i   (cmd_io_en_i),
    .state_o       (state)
  );

  pwr_status_enc u_enc (
    .state_i       (state),
    .wake_opt_i    (wake_opt_i),
    .bus_oe_o      (bus_oe_o),
    .wake_pin_oe_o (wake_pin_oe_o),
    .pwr_status_o  (pwr_status_o),
    .state_code_o  (state_o)
  );

  assign nvm_reload_o = release_pulse;
  assign wake_clr_o   = release_pulse;

  p_release_in_dr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_pulse |-> state == PS_DR);
  p_d0u_needs_settle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_D0U && $past(state) == PS_DR) |-> $past(settle_done));
  p_oe_off_in_dr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_DR) |-> (!bus_oe_o && wake_pin_oe_o));
endmodule

// File: tb/pwr_seq_tb.sv
`timescale 1ns/1ps
module pwr_seq_tb;
  localparam int SETTLE = 512;
  localparam logic [1:0] E_D0A = 2'b00, E_D0U = 2'b01, E_DR = 2'b10, E_D3 = 2'b11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_rst_ni = 1'b0;
  logic cfg_wr_i = 1'b0;
  logic [1:0] cfg_pstate_i = 2'b00;
  logic cmd_wr_i = 1'b0, cmd_mem_en_i = 1'b0, cmd_io_en_i = 1'b0;
  logic wake_opt_i = 1'b0;
  logic bus_oe_o, wake_pin_oe_o, nvm_reload_o, wake_clr_o;
  logic [1:0] pwr_status_o, state_o;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;
  string phase = "R11";

  always #2.5 clk_i = ~clk_i;

  pwr_seq #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk_i, .rst_ni, .bus_rst_ni, .cfg_wr_i, .cfg_pstate_i, .cmd_wr_i,
    .cmd_mem_en_i, .cmd_io_en_i, .wake_opt_i, .bus_oe_o, .wake_pin_oe_o,
    .nvm_reload_o, .wake_clr_o, .pwr_status_o, .state_o
  );

  // behavioural reference model
  logic hist[$];
  logic [1:0] m_state;
  int m_n;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_state = E_DR;
      m_n = 0;
    end else begin
      if (!hist[1]) begin
        m_state = E_DR;
        m_n = 0;
      end else begin
        case (m_state)
          E_D0A: if (cfg_wr_i && cfg_pstate_i == 2'b11) m_state = E_D3;
          E_D0U: if (cmd_wr_i && (cmd_mem_en_i || cmd_io_en_i)) m_state = E_D0A;
          E_DR: begin
            m_n = m_n + 1;
            if (m_n >= SETTLE) m_state = E_D0U;
          end
          default: ;
        endcase
      end
      hist.push_front(bus_rst_ni);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done_flag) begin
      logic exp_pulse;
      logic [1:0] exp_status;
      exp_pulse = hist[1] && !hist[2];
      exp_status = (m_state == E_D0A) ? 2'b11 :
                   (m_state == E_D0U) ? {1'b0, wake_opt_i} : 2'b00;
      chk(phase, "state_o", state_o, m_state);
      chk(phase, "bus_oe_o", bus_oe_o, (m_state == E_D0A || m_state == E_D0U));
      chk("R3", "wake_pin_oe_o", wake_pin_oe_o, 1);
      chk("R4", "nvm_reload_o", nvm_reload_o, exp_pulse);
      chk("R4", "wake_clr_o", wake_clr_o, exp_pulse);
      chk(phase, "pwr_status_o", pwr_status_o, exp_status);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    #0.5;
  endtask

  task automatic cfg_write(input logic [1:0] v);
    cfg_wr_i = 1'b1; cfg_pstate_i = v;
    step(1);
    cfg_wr_i = 1'b0; cfg_pstate_i = 2'b00;
  endtask

  task automatic cmd_write(input logic mem, input logic io);
    cmd_wr_i = 1'b1; cmd_mem_en_i = mem; cmd_io_en_i = io;
    step(1);
    cmd_wr_i = 1'b0; cmd_mem_en_i = 1'b0; cmd_io_en_i = 1'b0;
  endtask

  // raise bus reset; check pulse timing and settle length
  task automatic release_and_settle(input string req);
    int c;
    bus_rst_ni = 1'b1;
    step(2);
    chk("R4", "release pulse", nvm_reload_o, 1);
    c = 0;
    while (state_o !== E_D0U && c < SETTLE + 20) begin
      step(1);
      c++;
      if (c == 1) chk("R4", "pulse width", wake_clr_o, 0);
    end
    chk(req, "cycles pulse to D0U", c, SETTLE);
  endtask

  task automatic finish_run;
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R11", "reset state", state_o, E_DR);
    chk("R3", "reset oe", bus_oe_o, 0);
    rst_ni = 1'b1;
    step(5);
    phase = "R5";
    release_and_settle("R5");

    phase = "R6";
    wake_opt_i = 1'b1; step(1);
    chk("R6", "status wake on", pwr_status_o, 2'b01);
    wake_opt_i = 1'b0; step(1);
    chk("R6", "status wake off", pwr_status_o, 2'b00);

    phase = "R8";
    step(1000);
    cmd_write(1'b0, 1'b0);
    step(1);
    chk("R8", "D0U held", state_o, E_D0U);

    phase = "R7";
    cmd_write(1'b0, 1'b1);
    chk("R7", "io enable to D0A", state_o, E_D0A);
    chk("R7", "active status", pwr_status_o, 2'b11);

    phase = "R9";
    cfg_write(2'b00); cfg_write(2'b01); cfg_write(2'b10);
    cmd_write(1'b1, 1'b1);
    chk("R9", "D0A held", state_o, E_D0A);

    phase = "R1";
    cfg_write(2'b11);
    chk("R1", "to D3", state_o, E_D3);
    chk("R11", "D3 status", pwr_status_o, 2'b00);

    phase = "R2";
    step(2000);
    cfg_write(2'b00);
    cmd_write(1'b1, 1'b0);
    step(1);
    chk("R2", "D3 held", state_o, E_D3);

    phase = "R3";
    bus_rst_ni = 1'b0;
    step(2);
    chk("R3", "not yet DR", state_o, E_D3);
    step(1);
    chk("R3", "DR after sync", state_o, E_DR);
    chk("R3", "oe off", bus_oe_o, 0);
    step(5);

    phase = "R10";
    bus_rst_ni = 1'b1;
    step(200);
    cmd_write(1'b1, 1'b0);
    chk("R9", "cmd during settle", state_o, E_DR);
    bus_rst_ni = 1'b0;
    step(4);
    release_and_settle("R10");

    phase = "R7";
    cmd_write(1'b1, 1'b0);
    chk("R7", "mem enable to D0A", state_o, E_D0A);

    phase = "R3";
    bus_rst_ni = 1'b0;
    step(3);
    chk("R3", "D0A to DR", state_o, E_DR);
    phase = "R5";
    release_and_settle("R5");
    phase = "R3";
    bus_rst_ni = 1'b0;
    step(3);
    chk("R3", "D0U to DR", state_o, E_DR);
    step(3);
    finish_run();
  end
endmodule